// File: doc/BRIEF.md
# CAN Frame Serializer with Bit Stuffing

This block turns a frame descriptor into the serial bit stream of a CAN data or remote frame. The descriptor holds a format select (base or extended identifier), the remote-request flag, a 29-bit identifier, a 4-bit length code, eight payload bytes and a precomputed 15-bit CRC. A start pulse while idle captures the descriptor. From then on the block emits one bit on its serial output for every bit-time enable pulse.

The emitted frame is the start-of-frame bit, the arbitration and control fields, the payload bytes, the CRC field and then a fixed recessive trailer. Between the start-of-frame bit and the end of the CRC field the block inserts complement bits after every run of five equal bits. The busy output covers the whole frame, and a one-clock done pulse marks its end. The surrounding controller supplies the bit timing, the CRC and all bus-level error handling.

Top module: `can_frame_tx`

## Requirements
- R1: After reset and whenever the block is idle, tx_bit is 1 (recessive), busy is 0 and done is 0.
- R2: A start pulse while idle captures the descriptor and busy is 1 from the next clock. A start pulse while busy has no effect on the frame being sent.
- R3: tx_bit changes only on clocks where bit_en is 1. The first bit_en after a start drives the start-of-frame bit, which is 0.
- R4: With ext_fmt=0, the bits after start-of-frame are ident[10:0] MSB first, then rtr, then two 0 bits, then dlc[3:0] MSB first.
- R5: With ext_fmt=1, the bits after start-of-frame are ident[28:18], two 1 bits, ident[17:0], rtr, two 0 bits, then dlc[3:0], each field MSB first.
- R6: The payload follows the length code. Byte k is payload[63-8k -: 8], sent in order k = 0, 1, … and MSB first. The number of bytes is min(dlc, 8), or zero when rtr is 1.
- R7: The 15 CRC bits follow the payload, crc[14] first.
- R8: After five consecutive equal bits on tx_bit, the block inserts one bit of the opposite value. Inserted bits count toward runs, so an inserted bit starts a new run of length one.
- R9: Stuffing covers the start-of-frame bit through the last CRC bit, including an inserted bit right after the last CRC bit when that bit completes a run of five. The trailer is never stuffed.
- R10: After the stuffed section, 13 bits of 1 follow. At the next bit_en, busy falls and done is 1 for exactly that one clock, while tx_bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock pulse per bit time; advances the output |
| start | input | 1 | Request to send the descriptor on the inputs |
| ext_fmt | input | 1 | 1 selects the 29-bit identifier layout |
| rtr | input | 1 | Remote-request flag |
| ident | input | 29 | Identifier; base format uses bits 10:0 |
| dlc | input | 4 | Data length code |
| payload | input | 64 | Payload bytes, byte 0 in bits 63:56 |
| crc | input | 15 | Precomputed CRC field |
| tx_bit | output | 1 | Serial bit stream, 1 = recessive |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The assertions check rules that hold on every clock: the line is recessive when idle and during the trailer, the output holds between bit enables, an inserted bit always complements the previous bit, the run counter never passes five, the bit buffer is never read past its end, and done lasts one clock and coincides with the return to idle. The field order, the payload byte count under the remote flag and the length code clipping, and the exact places where stuff bits fall can only be shown by the bench. For this, the bench compares whole captured streams against a model of its own. The bench scenarios also cover a start ignored mid-frame and a long pause in the enables.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

  localparam int ID_W      = 29;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int CRC_W     = 15;
  // start-of-frame bit included in both header sizes
  localparam int STD_HDR   = 1 + 11 + 1 + 2 + DLC_W;
  localparam int EXT_HDR   = 1 + 11 + 2 + 18 + 1 + 2 + DLC_W;
  localparam int FRAME_W   = EXT_HDR + DATA_W + CRC_W;
  localparam int LEN_W     = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic              ext;
    logic              rtr;
    logic [ID_W-1:0]   ident;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] payload;
    logic [CRC_W-1:0]  crc;
  } can_desc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_STUFFED, ST_TAIL} tx_state_t;

  // payload bytes actually placed on the wire
  function automatic int unsigned payload_bytes(logic rtr, logic [DLC_W-1:0] dlc);
    if (rtr) return 0;
    if (int'(dlc) > MAX_BYTES) return MAX_BYTES;
    return int'(dlc);
  endfunction

  // unstuffed bit count from start-of-frame through the last CRC bit
  function automatic logic [LEN_W-1:0] frame_bits(can_desc_t d);
    int unsigned n;
    n = (d.ext ? EXT_HDR : STD_HDR) + 8 * payload_bytes(d.rtr, d.dlc) + CRC_W;
    return LEN_W'(n);
  endfunction

  // left-aligned raw frame: the first bit on the wire sits at the MSB
  function automatic logic [FRAME_W-1:0] pack_frame(can_desc_t d);
    logic [FRAME_W-1:0] acc;
    int unsigned nb;
    nb = payload_bytes(d.rtr, d.dlc);
    if (d.ext)
      acc = FRAME_W'({1'b0, d.ident[28:18], 2'b11, d.ident[17:0], d.rtr, 2'b00, d.dlc});
    else
      acc = FRAME_W'({1'b0, d.ident[10:0], d.rtr, 2'b00, d.dlc});
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (i < int'(nb))
        acc = (acc << 8) | FRAME_W'(d.payload[DATA_W-1-8*i -: 8]);
    end
    acc = (acc << CRC_W) | FRAME_W'(d.crc);
    acc = acc << (FRAME_W - int'(frame_bits(d)));
    return acc;
  endfunction

endpackage

// File: rtl/can_tx_shifter.sv
module can_tx_shifter
  import can_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               advance,
  output logic               head_bit,
  output logic               avail
);

  logic [FRAME_W-1:0] bits_q;
  logic [LEN_W-1:0]   left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      left_q <= '0;
    end else if (load) begin
      bits_q <= frame_in;
      left_q <= len_in;
    end else if (advance) begin
      bits_q <= bits_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign head_bit = bits_q[FRAME_W-1];
  assign avail    = (left_q != '0);

  // R9: the raw bit stream is never consumed past its last CRC bit
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> avail);

endmodule

// File: rtl/can_tx_stuffer.sv
module can_tx_stuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic slot,
  input  logic raw_bit,
  input  logic raw_avail,
  output logic stuff_now,
  output logic stuff_bit
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic             last_q;
  logic [CNT_W-1:0] run_q;

  function automatic logic [CNT_W-1:0] run_after(logic b, logic prev, logic [CNT_W-1:0] run);
    return (b == prev) ? run + 1'b1 : CNT_W'(1);
  endfunction

  assign stuff_now = (run_q == CNT_W'(RUN_LEN));
  assign stuff_bit = ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (init) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (slot) begin
      if (stuff_now) begin
        last_q <= ~last_q;
        run_q  <= CNT_W'(1);
      end else if (raw_avail) begin
        last_q <= raw_bit;
        run_q  <= run_after(raw_bit, last_q, run_q);
      end
    end
  end

  // R8: a run never grows beyond the stuffing threshold
  a_r8_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CNT_W'(RUN_LEN));

  // R8: an inserted bit opens a fresh run of one
  a_r8_stuff_restarts_run: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && stuff_now && !init) |=> (run_q == CNT_W'(1)));

endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int TAIL_BITS = 13,
  parameter int RUN_LEN   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        start,
  input  logic        ext_fmt,
  input  logic        rtr,
  input  logic [28:0] ident,
  input  logic [3:0]  dlc,
  input  logic [63:0] payload,
  input  logic [14:0] crc,
  output logic        tx_bit,
  output logic        busy,
  output logic        done
);

  localparam int TAIL_W = $clog2(TAIL_BITS + 1);

  tx_state_t         state_q;
  logic [TAIL_W-1:0] tail_q;
  logic              tx_q;
  logic              done_q;
  can_desc_t         desc;

  // named internal events
  logic accept, slot, stuff_now, stuff_bit, head_bit, avail;
  logic take_raw, zone_end, tail_last;

  always_comb begin
    desc.ext     = ext_fmt;
    desc.rtr     = rtr;
    desc.ident   = ident;
    desc.dlc     = dlc;
    desc.payload = payload;
    desc.crc     = crc;
  end

  assign accept    = start && (state_q == ST_IDLE);
  assign slot      = bit_en && (state_q == ST_STUFFED);
  assign take_raw  = slot && !stuff_now && avail;
  assign zone_end  = slot && !stuff_now && !avail;
  assign tail_last = bit_en && (state_q == ST_TAIL) && (tail_q == TAIL_W'(TAIL_BITS));

  can_tx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (pack_frame(desc)),
    .len_in   (frame_bits(desc)),
    .advance  (take_raw),
    .head_bit (head_bit),
    .avail    (avail)
  );

  can_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (accept),
    .slot      (slot),
    .raw_bit   (head_bit),
    .raw_avail (avail),
    .stuff_now (stuff_now),
    .stuff_bit (stuff_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tail_q  <= '0;
      tx_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          tx_q <= 1'b1;
          if (accept) state_q <= ST_STUFFED;
        end
        ST_STUFFED: begin
          if (slot) begin
            if (stuff_now) begin
              tx_q <= stuff_bit;
            end else if (avail) begin
              tx_q <= head_bit;
            end else begin
              tx_q    <= 1'b1;
              tail_q  <= TAIL_W'(1);
              state_q <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tail_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (bit_en) begin
            tail_q <= tail_q + 1'b1;
          end
          tx_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_bit = tx_q;
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;

  // R1: the line rests recessive outside a frame
  a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_bit);

  // R3: without a bit enable the output holds
  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R8: an inserted bit is the complement of the bit before it
  a_r8_stuff_complements: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && stuff_now) |=> (tx_bit != $past(tx_bit)));

  // R9: the trailer carries no stuffing, only recessive bits
  a_r9_tail_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> tx_bit);

  // R10: done lasts a single clock
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done coincides with the return to idle on a recessive line
  a_r10_done_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tx_bit));

  // R10: zone end always enters the trailer with its first recessive bit
  a_r10_tail_entry: assert property (@(posedge clk) disable iff (!rst_n)
    zone_end |=> (state_q == ST_TAIL && tail_q == TAIL_W'(1)));

endmodule

// File: tb/can_frame_tx_tb_top.sv
module can_frame_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        start;
  logic        ext_fmt;
  logic        rtr;
  logic [28:0] ident;
  logic [3:0]  dlc;
  logic [63:0] payload;
  logic [14:0] crc;
  logic        tx_bit, busy, done;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  can_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
    .ext_fmt(ext_fmt), .rtr(rtr), .ident(ident), .dlc(dlc),
    .payload(payload), .crc(crc),
    .tx_bit(tx_bit), .busy(busy), .done(done)
  );

  // vector layout: {ext, rtr, ident[28:0], dlc[3:0], payload[63:0], crc[14:0]}
  localparam int VW = 1 + 1 + 29 + 4 + 64 + 15;
  localparam int NV = 6;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b0, 29'h0000000,  4'd0,  64'h0,                  15'h0000},
    {1'b0, 1'b1, 29'h00007FF,  4'd5,  64'hFFFF_FFFF_FFFF_FFFF, 15'h7FFF},
    {1'b1, 1'b0, 29'h1ABCDEF5, 4'd8,  64'h0123_4567_89AB_CDEF, 15'h2A11},
    {1'b1, 1'b0, 29'h1FFFFFFF, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 15'h0000},
    {1'b0, 1'b0, 29'h00000A6,  4'd2,  64'hA5C3_0000_0000_0000, 15'h1234},
    {1'b1, 1'b1, 29'h0000000,  4'd3,  64'h1111_2222_3333_4444, 15'h7FFF}
  };
  localparam string TAGS [NV] = '{
    "R3 R4 R7 R8 R9",
    "R4 R6 R7 R8",
    "R5 R6 R7 R8",
    "R5 R6 R8 R9",
    "R4 R6 R7",
    "R5 R6 R8 R10"
  };

  logic exp_q[$];
  logic got_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bench model: field-by-field bit list, then stuffing over the whole list
  task automatic model(input logic [VW-1:0] v);
    logic        e, r;
    logic [28:0] id;
    logic [3:0]  l;
    logic [63:0] pl;
    logic [14:0] c;
    logic        raw[$];
    int          nb, run;
    logic        prev;
    {e, r, id, l, pl, c} = v;
    raw.delete();
    raw.push_back(1'b0);
    if (e) begin
      for (int k = 28; k >= 18; k--) raw.push_back(id[k]);
      raw.push_back(1'b1);
      raw.push_back(1'b1);
      for (int k = 17; k >= 0; k--) raw.push_back(id[k]);
    end else begin
      for (int k = 10; k >= 0; k--) raw.push_back(id[k]);
    end
    raw.push_back(r);
    raw.push_back(1'b0);
    raw.push_back(1'b0);
    for (int k = 3; k >= 0; k--) raw.push_back(l[k]);
    nb = r ? 0 : ((l > 4'd8) ? 8 : int'(l));
    for (int b = 0; b < nb; b++)
      for (int k = 63 - 8*b; k >= 56 - 8*b; k--) raw.push_back(pl[k]);
    for (int k = 14; k >= 0; k--) raw.push_back(c[k]);
    exp_q.delete();
    run  = 0;
    prev = 1'b1;
    foreach (raw[i]) begin
      exp_q.push_back(raw[i]);
      run  = (raw[i] == prev) ? run + 1 : 1;
      prev = raw[i];
      if (run == 5) begin
        exp_q.push_back(~prev);
        prev = ~prev;
        run  = 1;
      end
    end
    for (int k = 0; k < 13; k++) exp_q.push_back(1'b1);
  endtask

  task automatic drive_desc(input logic [VW-1:0] v);
    {ext_fmt, rtr, ident, dlc, payload, crc} = v;
  endtask

  // one bit time: a single enabled clock then three idle clocks
  task automatic bit_slot(output logic t, output logic d);
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    t = tx_bit;
    d = done;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input int idx, input bit disturb);
    logic t, d, held;
    bit   stable_ok, ok;
    int   first_bad;
    model(VEC[idx]);
    got_q.delete();
    @(negedge clk);
    drive_desc(VEC[idx]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!disturb) check(busy == 1'b1, "R2 busy after start", busy, 1);
    d = 1'b0;
    for (int s = 0; s < 400 && !d; s++) begin
      bit_slot(t, d);
      if (!d) got_q.push_back(t);
      if (disturb && got_q.size() == 10) begin
        held = tx_bit;
        stable_ok = 1'b1;
        repeat (20) begin
          @(negedge clk);
          if (tx_bit != held) stable_ok = 1'b0;
        end
        check(stable_ok, "R3 tx held with no bit_en", tx_bit, held);
        // second start while busy, with a different descriptor
        drive_desc({1'b0, 1'b0, 29'h0000555, 4'd1, 64'h0, 15'h0});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    check(got_q.size() == exp_q.size(), $sformatf("%s R10 stream length vec %0d", TAGS[idx], idx),
          got_q.size(), exp_q.size());
    ok = 1'b1;
    first_bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      if (got_q[i] !== exp_q[i] && first_bad < 0) begin
        ok = 1'b0;
        first_bad = i;
      end
    end
    if (disturb)
      check(ok, "R2 frame unaffected by start while busy", first_bad, -1);
    else
      check(ok, $sformatf("%s stream content vec %0d (first bad bit)", TAGS[idx], idx), first_bad, -1);
    check(d && !busy && tx_bit, "R10 done with idle recessive line", {d, busy, tx_bit}, 3'b101);
    @(negedge clk);
    check(!done && !busy && tx_bit, "R10 R1 done single clock then idle", {done, busy, tx_bit}, 3'b001);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    bit_en = 1'b0;
    start  = 1'b0;
    drive_desc('0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bit && !busy && !done, "R1 reset state", {tx_bit, busy, done}, 3'b100);

    for (int i = 0; i < NV; i++) run_frame(i, 1'b0);

    // directed: pause in enables and a start pulse during a frame
    run_frame(2, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule